// File: doc/BRIEF.md
# Eight-Pin I/O Port with Function Takeover

This block is one general-purpose I/O port of a small controller. It has eight pins and three registers on a simple register bus. The output latch holds the values the pins drive. The direction register decides, pin by pin, whether a pin drives or only listens. The assignment register hands the six low pins to the memory-expansion address lines. Reads are combinational from the address; writes are captured on the rising clock edge while the write strobe is high.

When an alternate function owns a pin, the pin is forced to drive and carries that function's signal. The direction bit for that pin keeps whatever software last stored and takes control again once the function lets go. The top pin is claimed differently. No register bit controls it. An operating-mode input does: in the expanded or test mode, the top pin carries the bus read/write strobe. Pads, pull-ups and the sources of the address and strobe signals are outside the block.

Top module: `gpio_override_port`

## Requirements
- R1: After a clock edge with `rst_n` low, the output latch, the direction register and the assignment register are all zero. With `mode_expanded` low, `pin_oe` and `pin_out` are then all zero.
- R2: The port register sits at address 0x7E, the direction register at 0x7F and the assignment register at 0x2D. A read of any other address returns zero, and a write to any other address changes no register.
- R3: A write takes effect on the rising edge at which `bus_wr` is high. The direction register reads back exactly the value written, in every mode and under any override.
- R4: For a pin that no function owns, direction bit 0 gives `pin_oe` 0 and `pin_out` 0. Direction bit 1 gives `pin_oe` 1, with `pin_out` equal to the latch bit.
- R5: When assignment bit k (k = 0..5) is 1, pin k has `pin_oe` 1 and `pin_out` equal to `alt_addr[k]`, which is expansion address bit 13+k. The direction register is left unchanged, and it controls the pin again once the bit is cleared.
- R6: While `mode_expanded` is 1, pin 7 has `pin_oe` 1 and `pin_out` equal to `alt_rw`. Direction bit 7 keeps its stored value.
- R7: Bits 7:6 of the assignment register always read as zero, whatever value was written.
- R8: For a port register read, each bit returns the latch bit if the pin is an output that no function owns. Otherwise the bit returns `pin_in`.
- R9: A port register write updates all eight latch bits, including those of input pins. A stored bit appears on its pin once the pin becomes a general-purpose output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| mode_expanded | input | 1 | 1 = expanded or test mode, 0 = single-chip |
| alt_addr | input | 6 | Expansion address bits 13..18, bit 0 = address bit 13 |
| alt_rw | input | 1 | Bus read/write strobe for pin 7 |
| pin_in | input | 8 | Sampled pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin driven value |

## Verification
The assertions assume that `bus_addr`, `bus_wr` and `bus_wdata` are stable around the rising edge. They also assume that `mode_expanded`, `alt_addr` and `alt_rw` change only between edges, so any combinational pin relation holds at the sampling point. The stimulus changes every input one time unit after a rising edge and holds `bus_wr` high for exactly one edge per write. It reads only after the write edge has passed, so reads never overlap a write in the same cycle.

// File: rtl/gpio_port_pkg.sv
// Shared types for the I/O port.
// Assumes: the register decode resolves to at most one register at a time.
package gpio_port_pkg;
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_DIR    = 2'd2,
        SEL_ASSIGN = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
// Register storage for the port: output latch, direction and assignment.
// Decodes the bus address into a register select.
// Assumes: the register offsets are distinct, and ALT_W < WIDTH.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int ALT_W      = 6,
    parameter int ADDR_W     = 8,
    parameter int DATA_OFS   = 'h7E,
    parameter int DIR_OFS    = 'h7F,
    parameter int ASSIGN_OFS = 'h2D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output reg_sel_e          sel,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [ALT_W-1:0]  assign_q
);
    localparam logic [ADDR_W-1:0] DATA_A   = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] DIR_A    = ADDR_W'(DIR_OFS);
    localparam logic [ADDR_W-1:0] ASSIGN_A = ADDR_W'(ASSIGN_OFS);

    // Address decode into a register select.
    always_comb begin
        if (bus_addr == DATA_A)        sel = SEL_DATA;
        else if (bus_addr == DIR_A)    sel = SEL_DIR;
        else if (bus_addr == ASSIGN_A) sel = SEL_ASSIGN;
        else                           sel = SEL_NONE;
    end

    // Register update on a write strobe, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q  <= '0;
            dir_q    <= '0;
            assign_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_DATA:   latch_q  <= bus_wdata;
                SEL_DIR:    dir_q    <= bus_wdata;
                SEL_ASSIGN: assign_q <= bus_wdata[ALT_W-1:0];
                default:    ;
            endcase
        end
    end

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_A) |=> (dir_q == $past(bus_wdata)));

    // R5 R6
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == DIR_A) |=> $stable(dir_q));

    // R2
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != DATA_A && bus_addr != DIR_A && bus_addr != ASSIGN_A)
        |=> ($stable(latch_q) && $stable(assign_q)));
endmodule

// File: rtl/gpio_pin_mux.sv
// Per-pin choice of driver: an assigned address line, the mode-claimed strobe,
// or the direction/latch pair. Also flags the pins that are general-purpose outputs.
// Assumes: STROBE_PIN >= ALT_W, so no pin has two takeover sources.
module gpio_pin_mux #(
    parameter int WIDTH      = 8,
    parameter int ALT_W      = 6,
    parameter int STROBE_PIN = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [ALT_W-1:0] assign_q,
    input  logic [ALT_W-1:0] alt_addr,
    input  logic             alt_rw,
    input  logic             mode_expanded,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] gp_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic owned;
        logic own_val;
        if (i < ALT_W) begin : g_addr
            // Address-line takeover for an assignable pin.
            always_comb begin
                owned   = assign_q[i];
                own_val = alt_addr[i];
            end
            // R5
            addr_takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
                assign_q[i] |-> (pin_oe[i] && pin_out[i] == alt_addr[i]));
        end else if (i == STROBE_PIN) begin : g_strobe
            // Mode-driven takeover for the strobe pin.
            always_comb begin
                owned   = mode_expanded;
                own_val = alt_rw;
            end
            // R6
            strobe_takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
                mode_expanded |-> (pin_oe[i] && pin_out[i] == alt_rw));
        end else begin : g_plain
            // No takeover source for this pin.
            always_comb begin
                owned   = 1'b0;
                own_val = 1'b0;
            end
        end

        // Final drive selection for the pin.
        always_comb begin
            gp_out[i]  = !owned && dir_q[i];
            pin_oe[i]  = owned || dir_q[i];
            pin_out[i] = owned ? own_val : (dir_q[i] & latch_q[i]);
        end

        // R4
        quiet_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_oe[i] |-> !pin_out[i]);
    end
endmodule

// File: rtl/gpio_readback.sv
// Read-data multiplexer for the port registers.
// Assumes: sel comes from the address decode of the same cycle.
module gpio_readback
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int ALT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [ALT_W-1:0] assign_q,
    input  logic [WIDTH-1:0] gp_out,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] rdata
);
    // Pick the read value for the selected register.
    always_comb begin
        case (sel)
            SEL_DATA:   rdata = (latch_q & gp_out) | (pin_in & ~gp_out);
            SEL_DIR:    rdata = dir_q;
            SEL_ASSIGN: rdata = WIDTH'(assign_q);
            default:    rdata = '0;
        endcase
    end

    // R7
    assign_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_ASSIGN) |-> (rdata[WIDTH-1:ALT_W] == '0));

    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (rdata == '0));
endmodule

// File: rtl/gpio_override_port.sv
// Top of the I/O port: registers, per-pin takeover multiplexing and readback.
// Assumes: bus inputs are synchronous to clk; alternate-function inputs are
// produced elsewhere and are valid whenever their takeover is active.
module gpio_override_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int ALT_W      = 6,
    parameter int ADDR_W     = 8,
    parameter int STROBE_PIN = 7,
    parameter int DATA_OFS   = 'h7E,
    parameter int DIR_OFS    = 'h7F,
    parameter int ASSIGN_OFS = 'h2D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              mode_expanded,
    input  logic [ALT_W-1:0]  alt_addr,
    input  logic              alt_rw,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_out
);
    reg_sel_e         sel;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [ALT_W-1:0] assign_q;
    logic [WIDTH-1:0] gp_out;

    gpio_port_regs #(
        .WIDTH(WIDTH), .ALT_W(ALT_W), .ADDR_W(ADDR_W),
        .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS), .ASSIGN_OFS(ASSIGN_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .sel(sel), .latch_q(latch_q), .dir_q(dir_q),
        .assign_q(assign_q)
    );

    gpio_pin_mux #(
        .WIDTH(WIDTH), .ALT_W(ALT_W), .STROBE_PIN(STROBE_PIN)
    ) u_mux (
        .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .latch_q(latch_q),
        .assign_q(assign_q), .alt_addr(alt_addr), .alt_rw(alt_rw),
        .mode_expanded(mode_expanded), .pin_oe(pin_oe), .pin_out(pin_out),
        .gp_out(gp_out)
    );

    gpio_readback #(
        .WIDTH(WIDTH), .ALT_W(ALT_W)
    ) u_rb (
        .clk(clk), .rst_n(rst_n), .sel(sel), .latch_q(latch_q), .dir_q(dir_q),
        .assign_q(assign_q), .gp_out(gp_out), .pin_in(pin_in), .rdata(bus_rdata)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        (!rst_n && !mode_expanded) |=> (pin_oe == '0 || !$past(!rst_n)) );
endmodule

// File: tb/sim_gpio_override_port.sv
// Scoreboard bench: the driver pushes expected items, the monitor compares them
// at the falling edge.
module sim_gpio_override_port;
    localparam int PERIOD = 10;
    localparam logic [7:0] A_DATA = 8'h7E;
    localparam logic [7:0] A_DIR  = 8'h7F;
    localparam logic [7:0] A_ASG  = 8'h2D;

    typedef struct {
        string      tag;
        int         kind;
        logic [7:0] exp;
    } item_t;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] bus_addr = 0;
    logic       bus_wr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       mode_expanded = 0;
    logic [5:0] alt_addr = 0;
    logic       alt_rw = 0;
    logic [7:0] pin_in = 0;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    item_t sb[$];

    gpio_override_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_expanded(mode_expanded),
        .alt_addr(alt_addr), .alt_rw(alt_rw), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out)
    );

    always #(PERIOD/2) clk = ~clk;

    // Monitor: compare every queued item at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? pin_oe : pin_out;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    // Push an expected read value for address a, then let one cycle pass.
    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        bus_addr = a;
        sb.push_back('{tag, 0, e});
        @(posedge clk); #1;
    endtask

    task automatic pins(input logic [7:0] oe, input logic [7:0] v, input string tag);
        sb.push_back('{tag, 1, oe});
        sb.push_back('{tag, 2, v});
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        pins(8'h00, 8'h00, "R1 pins after reset");
        rd(A_DIR, 8'h00, "R1 dir reset");
        rd(A_ASG, 8'h00, "R1 assign reset");
        rst_n = 1;
        rd(A_DATA, 8'h00, "R1 latch reset via read");
        // R3 R4 R8
        wr(A_DIR, 8'hF0);
        rd(A_DIR, 8'hF0, "R3 dir readback");
        wr(A_DATA, 8'hA5);
        pins(8'hF0, 8'hA0, "R4 gp outputs");
        pin_in = 8'h3C;
        rd(A_DATA, 8'hAC, "R8 mixed read");
        // R9 latch bits written while input
        wr(A_DIR, 8'hFF);
        pins(8'hFF, 8'hA5, "R9 latch shows on outputs");
        // R5 R7 takeover by address lines
        wr(A_DIR, 8'h0F);
        wr(A_ASG, 8'hFF);
        rd(A_ASG, 8'h3F, "R7 upper assign bits zero");
        alt_addr = 6'h2A;
        pins(8'h3F, 8'h2A, "R5 address takeover");
        rd(A_DIR, 8'h0F, "R5 dir kept");
        pin_in = 8'hC3;
        rd(A_DATA, 8'hC3, "R8 owned pins read pin level");
        wr(A_ASG, 8'h00);
        pins(8'h0F, 8'h05, "R5 dir resumes");
        // R6 strobe pin takeover
        mode_expanded = 1; alt_rw = 1;
        pins(8'h8F, 8'h85, "R6 strobe high");
        alt_rw = 0;
        pins(8'h8F, 8'h05, "R6 strobe low");
        rd(A_DIR, 8'h0F, "R6 dir bit7 kept");
        rd(A_DATA, 8'hC5, "R8 read in expanded mode");
        mode_expanded = 0;
        pins(8'h0F, 8'h05, "R6 pin7 released");
        // R2 unmapped address
        wr(8'h10, 8'h55);
        rd(8'h10, 8'h00, "R2 unmapped reads zero");
        rd(A_DIR, 8'h0F, "R2 dir untouched");
        rd(A_ASG, 8'h00, "R2 assign untouched");
        pins(8'h0F, 8'h05, "R2 latch untouched");
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule